// File: doc/BRIEF.md
# PLL Control Register Bank

This block is the byte-wide register file that sits between a processor bus and the phase-locked loop of a clock generator. It stores the loop's control, bandwidth, multiplier and VCO-range settings and drives them out as plain signals. It also decides which source feeds the base clock: the oscillator halved or the VCO halved. Software reaches the registers through a single-cycle bus with address, write data and write and read strobes. Read data is combinational and valid in the cycle the read strobe is high; otherwise it is zero.

Several interlocks tie the registers together. Automatic-bandwidth mode gates the lock flag, the live lock bit and the interrupt enable. The clock-select bit can only be set while the loop is on and the range is nonzero, and while it is set the loop cannot be switched off. A running loop freezes the multiplier and range programming. Write permissions are judged on the register values held before the write. The lock detector's status arrives on two inputs: a lock level and an acquisition level.

Top module: `pll_ctrl_regs`

## Requirements
- R1: After reset the six registers, read at offsets 0 to 5 from the base address, return 0x20 (control, loop-on bit 5 set), 0x00 (bandwidth), 0x00 (multiplier high), 0x40 (multiplier low), 0x40 (range) and 0x01 (reserved).
- R2: Offsets 0 to 5 map to control, bandwidth, multiplier high, multiplier low, range and reserved. The reserved offset always reads 0x01, any address outside the window reads 0x00, and read data is 0x00 while the read strobe is low.
- R3: While the automatic bit (bandwidth bit 7) is 0, the interrupt enable (control bit 7) stays 0 and ignores writes. The lock flag (control bit 6) and the lock bit (bandwidth bit 6) read 0, and the interrupt output stays low.
- R4: While the automatic bit is 1, bandwidth bit 5 reads the acquisition input and ignores writes. While the automatic bit is 0, bandwidth bit 5 is a writable storage bit. Bandwidth bits 4:0 read 0.
- R5: With the automatic bit at 1, any change of the lock input between consecutive clock edges sets the lock flag. A read of the control offset clears it, and a set in the same cycle takes priority over the clear.
- R6: The interrupt output is high exactly when the lock flag and the interrupt enable are both 1.
- R7: The clock-select bit (control bit 4) accepts a 1 only if the loop-on bit was already 1 and the range register is nonzero. Otherwise it holds 0.
- R8: While the clock-select bit is 1, the loop-on bit (control bit 5) stays 1 and writes to it are ignored.
- R9: While the loop-on bit is 1, writes to the multiplier and range registers are ignored. While it is 0, the multiplier high register takes bits 11:8 from write bits 3:0, and its upper nibble reads 0.
- R10: The base clock output toggles on each rising edge of the oscillator clock when clock select is 0, and on each rising edge of the VCO clock when clock select is 1.
- R11: Control bits 1:0 form a freely writable prescaler field, driven on the prescaler output. Control bits 3:2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Bus byte address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 8 | Read data, valid while rd_en_i is high |
| lock_i | input | 1 | Lock status from the lock detector |
| acq_i | input | 1 | Acquisition status from the lock detector |
| osc_clk_i | input | 1 | Oscillator clock |
| vco_clk_i | input | 1 | VCO clock |
| mul_o | output | MUL_W | Loop multiplier |
| range_o | output | RNG_W | VCO range setting |
| prescale_o | output | 2 | VCO prescaler field |
| pll_en_o | output | 1 | Loop enable |
| clk_sel_o | output | 1 | Base clock source select, 1 = VCO |
| base_clk_o | output | 1 | Selected clock divided by two |
| irq_o | output | 1 | Lock-change interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit address space with the window at 0x36, a 12-bit multiplier and an 8-bit range. Random addresses are drawn from a span two locations wider than the window on each side, so the out-of-window reads and the whole register map are hit often. Since write data is random, every interlock order comes up: clock select attempted with the loop off or a zero range, the loop switched off under clock select, and programming tried while the loop runs. A bench model of the register rules predicts every read and output.

// File: rtl/pllr_pkg.sv
package pllr_pkg;

    localparam int NREG = 6;

    typedef enum logic [2:0] {
        RG_CTRL = 3'd0,
        RG_BW   = 3'd1,
        RG_MULH = 3'd2,
        RG_MULL = 3'd3,
        RG_RNG  = 3'd4,
        RG_RSV  = 3'd5
    } reg_idx_e;

    localparam logic [7:0] RSV_VALUE = 8'h01;

    typedef struct packed {
        logic       int_en;
        logic       flag;
        logic       loop_on;
        logic       src_sel;
        logic [1:0] presc;
        logic       auto_bw;
        logic       acq_bit;
        logic       lock_seen;
    } ctl_state_t;

endpackage

// File: rtl/pllr_ctrl.sv
module pllr_ctrl
    import pllr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic       wr_bw,
    input  logic       rd_ctrl,
    input  logic [7:0] wdata,
    input  logic       lock_i,
    input  logic       range_nz,
    output logic       int_en,
    output logic       flag,
    output logic       loop_on,
    output logic       src_sel,
    output logic [1:0] presc,
    output logic       auto_bw,
    output logic       acq_bit
);

    ctl_state_t st_d, st_q;
    logic       lock_chg;

    always_comb begin
        st_d     = st_q;
        lock_chg = lock_i ^ st_q.lock_seen;
        st_d.lock_seen = lock_i;

        // bandwidth register: permissions judged on the stored mode
        if (wr_bw) begin
            st_d.auto_bw = wdata[7];
            if (!st_q.auto_bw) begin
                st_d.acq_bit = wdata[5];
            end
        end

        // control register
        if (wr_ctrl) begin
            st_d.int_en  = wdata[7] & st_q.auto_bw;
            st_d.loop_on = st_q.src_sel ? 1'b1 : wdata[5];
            st_d.src_sel = wdata[4] & st_q.loop_on & range_nz;
            st_d.presc   = wdata[1:0];
        end

        // cross-register forcing on the next state
        st_d.int_en  = st_d.int_en & st_d.auto_bw;
        st_d.src_sel = st_d.src_sel & st_d.loop_on & range_nz;

        // lock flag: clear by control read, drop in manual mode, set wins
        if (rd_ctrl) begin
            st_d.flag = 1'b0;
        end
        if (!st_q.auto_bw) begin
            st_d.flag = 1'b0;
        end
        if (st_q.auto_bw && lock_chg) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{int_en: 1'b0, flag: 1'b0, loop_on: 1'b1, src_sel: 1'b0,
                      presc: 2'b00, auto_bw: 1'b0, acq_bit: 1'b0,
                      lock_seen: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign int_en  = st_q.int_en;
    assign flag    = st_q.flag;
    assign loop_on = st_q.loop_on;
    assign src_sel = st_q.src_sel;
    assign presc   = st_q.presc;
    assign auto_bw = st_q.auto_bw;
    assign acq_bit = st_q.acq_bit;

endmodule

// File: rtl/pllr_prog.sv
module pllr_prog #(
    parameter int               MUL_W   = 12,
    parameter int               RNG_W   = 8,
    parameter logic [MUL_W-1:0] MUL_RST = MUL_W'(12'h040),
    parameter logic [RNG_W-1:0] RNG_RST = RNG_W'(8'h40)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mulh,
    input  logic             wr_mull,
    input  logic             wr_rng,
    input  logic [7:0]       wdata,
    input  logic             frozen,
    output logic [MUL_W-1:0] mul_q,
    output logic [RNG_W-1:0] rng_q,
    output logic             rng_nz
);

    localparam int MUL_HI_W = MUL_W - 8;

    logic [MUL_W-1:0] mul_d;
    logic [RNG_W-1:0] rng_d;

    always_comb begin
        mul_d = mul_q;
        rng_d = rng_q;
        if (!frozen) begin
            if (wr_mulh) begin
                mul_d[MUL_W-1:8] = wdata[MUL_HI_W-1:0];
            end
            if (wr_mull) begin
                mul_d[7:0] = wdata;
            end
            if (wr_rng) begin
                rng_d = wdata[RNG_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mul_q <= MUL_RST;
            rng_q <= RNG_RST;
        end else begin
            mul_q <= mul_d;
            rng_q <= rng_d;
        end
    end

    assign rng_nz = |rng_q;

endmodule

// File: rtl/pllr_rdmux.sv
module pllr_rdmux
    import pllr_pkg::*;
#(
    parameter int MUL_W = 12,
    parameter int RNG_W = 8
) (
    input  logic             rd_en,
    input  logic             hit,
    input  logic [2:0]       idx,
    input  logic             int_en,
    input  logic             flag,
    input  logic             loop_on,
    input  logic             src_sel,
    input  logic [1:0]       presc,
    input  logic             auto_bw,
    input  logic             acq_bit,
    input  logic             lock_i,
    input  logic             acq_i,
    input  logic [MUL_W-1:0] mul_q,
    input  logic [RNG_W-1:0] rng_q,
    output logic [7:0]       rdata
);

    logic [7:0] ctrl_byte;
    logic [7:0] bw_byte;
    logic       acq_view;

    always_comb begin
        acq_view  = auto_bw ? acq_i : acq_bit;
        ctrl_byte = {int_en, flag & auto_bw, loop_on, src_sel, 2'b00, presc};
        bw_byte   = {auto_bw, auto_bw & lock_i, acq_view, 5'b00000};
        rdata     = 8'h00;
        if (rd_en && hit) begin
            case (reg_idx_e'(idx))
                RG_CTRL: rdata = ctrl_byte;
                RG_BW:   rdata = bw_byte;
                RG_MULH: rdata = 8'(mul_q >> 8);
                RG_MULL: rdata = mul_q[7:0];
                RG_RNG:  rdata = 8'(rng_q);
                RG_RSV:  rdata = RSV_VALUE;
                default: rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/pllr_clksel.sv
module pllr_clksel (
    input  logic       rst_n,
    input  logic [1:0] src_clk,
    input  logic       sel,
    output logic       base_clk
);

    logic [1:0] half;

    for (genvar g = 0; g < 2; g++) begin : g_div
        logic half_q;
        always_ff @(posedge src_clk[g] or negedge rst_n) begin
            if (!rst_n) begin
                half_q <= 1'b0;
            end else begin
                half_q <= ~half_q;
            end
        end
        assign half[g] = half_q;
    end

    assign base_clk = half[sel];

endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs
    import pllr_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(8'h36),
    parameter int                MUL_W     = 12,
    parameter int                RNG_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [7:0]        rdata_o,
    input  logic              lock_i,
    input  logic              acq_i,
    input  logic              osc_clk_i,
    input  logic              vco_clk_i,
    output logic [MUL_W-1:0]  mul_o,
    output logic [RNG_W-1:0]  range_o,
    output logic [1:0]        prescale_o,
    output logic              pll_en_o,
    output logic              clk_sel_o,
    output logic              base_clk_o,
    output logic              irq_o
);

    logic [ADDR_W-1:0] off;
    logic              hit;
    logic [NREG-1:0]   reg_sel;

    assign off = addr_i - BASE_ADDR;
    assign hit = off < ADDR_W'(NREG);

    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign reg_sel[g] = hit && (off == ADDR_W'(g));
    end

    logic       int_en_w, flag_w, loop_on_w, src_sel_w, auto_w, acq_bit_w, rng_nz_w;
    logic [1:0] presc_w;

    pllr_ctrl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_en_i & reg_sel[RG_CTRL]),
        .wr_bw    (wr_en_i & reg_sel[RG_BW]),
        .rd_ctrl  (rd_en_i & reg_sel[RG_CTRL]),
        .wdata    (wdata_i),
        .lock_i   (lock_i),
        .range_nz (rng_nz_w),
        .int_en   (int_en_w),
        .flag     (flag_w),
        .loop_on  (loop_on_w),
        .src_sel  (src_sel_w),
        .presc    (presc_w),
        .auto_bw  (auto_w),
        .acq_bit  (acq_bit_w)
    );

    pllr_prog #(
        .MUL_W (MUL_W),
        .RNG_W (RNG_W)
    ) u_prog (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mulh (wr_en_i & reg_sel[RG_MULH]),
        .wr_mull (wr_en_i & reg_sel[RG_MULL]),
        .wr_rng  (wr_en_i & reg_sel[RG_RNG]),
        .wdata   (wdata_i),
        .frozen  (loop_on_w),
        .mul_q   (mul_o),
        .rng_q   (range_o),
        .rng_nz  (rng_nz_w)
    );

    pllr_rdmux #(
        .MUL_W (MUL_W),
        .RNG_W (RNG_W)
    ) u_rd (
        .rd_en   (rd_en_i),
        .hit     (hit),
        .idx     (off[2:0]),
        .int_en  (int_en_w),
        .flag    (flag_w),
        .loop_on (loop_on_w),
        .src_sel (src_sel_w),
        .presc   (presc_w),
        .auto_bw (auto_w),
        .acq_bit (acq_bit_w),
        .lock_i  (lock_i),
        .acq_i   (acq_i),
        .mul_q   (mul_o),
        .rng_q   (range_o),
        .rdata   (rdata_o)
    );

    pllr_clksel u_clk (
        .rst_n    (rst_n),
        .src_clk  ({vco_clk_i, osc_clk_i}),
        .sel      (src_sel_w),
        .base_clk (base_clk_o)
    );

    assign prescale_o = presc_w;
    assign pll_en_o   = loop_on_w;
    assign clk_sel_o  = src_sel_w;
    assign irq_o      = flag_w & int_en_w;

endmodule

// File: rtl/pllr_chk.sv
module pllr_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(8'h36),
    parameter int                MUL_W     = 12,
    parameter int                RNG_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pll_en,
    input logic              clk_sel,
    input logic [MUL_W-1:0]  mul,
    input logic [RNG_W-1:0]  range_v,
    input logic              irq,
    input logic              int_en,
    input logic              auto_bw,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata
);

    AST_BCS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel |-> (pll_en && (range_v != '0))); // R7

    AST_LOOP_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clk_sel) |-> pll_en); // R8

    AST_PROG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pll_en) |-> ($stable(mul) && $stable(range_v))); // R9

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (int_en && auto_bw)); // R6

    AST_MANUAL_NO_IE: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_bw |-> !int_en); // R3

    AST_RSV_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == BASE_ADDR + ADDR_W'(5))) |-> (rdata == 8'h01)); // R2

endmodule

bind pll_ctrl_regs pllr_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .MUL_W     (MUL_W),
    .RNG_W     (RNG_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pll_en  (pll_en_o),
    .clk_sel (clk_sel_o),
    .mul     (mul_o),
    .range_v (range_o),
    .irq     (irq_o),
    .int_en  (int_en_w),
    .auto_bw (auto_w),
    .rd_en   (rd_en_i),
    .addr    (addr_i),
    .rdata   (rdata_o)
);

// File: tb/pll_ctrl_regs_tb.sv
module pll_ctrl_regs_tb;

    localparam logic [7:0] A_CTRL = 8'h36, A_BW = 8'h37, A_MULH = 8'h38,
                           A_MULL = 8'h39, A_RNG = 8'h3A, A_RSV = 8'h3B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0, wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  rdata;
    logic        lock = 1'b0, acq = 1'b0, osc = 1'b0, vco = 1'b0;
    logic [11:0] mul;
    logic [7:0]  rng;
    logic [1:0]  presc;
    logic        pll_en, clk_sel, base_clk, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] last_rd;

    // model state
    bit         m_ie, m_f, m_on, m_bcs, m_auto, m_acq, m_lk, m_od, m_vd;
    bit  [1:0]  m_vpr;
    bit  [11:0] m_mul;
    bit  [7:0]  m_rng;

    always #10 clk = ~clk;

    pll_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata),
        .lock_i(lock), .acq_i(acq), .osc_clk_i(osc), .vco_clk_i(vco),
        .mul_o(mul), .range_o(rng), .prescale_o(presc), .pll_en_o(pll_en),
        .clk_sel_o(clk_sel), .base_clk_o(base_clk), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a, input bit rd,
                                              input bit lk, input bit aq);
        if (!rd) return 8'h00;
        case (a)
            A_CTRL: return {m_ie, m_f & m_auto, m_on, m_bcs, 2'b00, m_vpr};
            A_BW:   return {m_auto, m_auto & lk, m_auto ? aq : m_acq, 5'b0};
            A_MULH: return {4'h0, m_mul[11:8]};
            A_MULL: return m_mul[7:0];
            A_RNG:  return m_rng;
            A_RSV:  return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_ie = 0; m_f = 0; m_on = 1; m_bcs = 0; m_vpr = 0; m_auto = 0;
        m_acq = 0; m_lk = 0; m_mul = 12'h040; m_rng = 8'h40; m_od = 0; m_vd = 0;
    endtask

    task automatic model_update(input bit wr, input bit rd, input logic [7:0] a,
                                input logic [7:0] wd, input bit lk);
        bit n_ie = m_ie, n_f = m_f, n_on = m_on, n_bcs = m_bcs;
        bit n_auto = m_auto, n_acq = m_acq;
        bit [1:0] n_vpr = m_vpr;
        bit [11:0] n_mul = m_mul;
        bit [7:0] n_rng = m_rng;
        bit chg = (lk != m_lk);
        if (wr && a == A_BW) begin
            n_auto = wd[7];
            if (!m_auto) n_acq = wd[5];
        end
        if (wr && a == A_CTRL) begin
            n_ie  = wd[7] & m_auto;
            n_on  = m_bcs ? 1'b1 : wd[5];
            n_bcs = wd[4] & m_on & (m_rng != 0);
            n_vpr = wd[1:0];
        end
        n_ie  = n_ie & n_auto;
        n_bcs = n_bcs & n_on & (m_rng != 0);
        if (rd && a == A_CTRL) n_f = 0;
        if (!m_auto) n_f = 0;
        if (m_auto && chg) n_f = 1;
        if (wr && !m_on) begin
            if (a == A_MULH) n_mul[11:8] = wd[3:0];
            if (a == A_MULL) n_mul[7:0] = wd;
            if (a == A_RNG)  n_rng = wd;
        end
        m_ie = n_ie; m_f = n_f; m_on = n_on; m_bcs = n_bcs; m_auto = n_auto;
        m_acq = n_acq; m_vpr = n_vpr; m_mul = n_mul; m_rng = n_rng; m_lk = lk;
    endtask

    task automatic step(input bit wr, input bit rd, input logic [7:0] a,
                        input logic [7:0] wd, input bit lk, input bit aq, input string tag);
        @(negedge clk);
        chk("R9 multiplier", 16'(mul), 16'(m_mul));
        chk("R9 range", 16'(rng), 16'(m_rng));
        chk("R11 prescaler", 16'(presc), 16'(m_vpr));
        chk("R8 loop enable", 16'(pll_en), 16'(m_on));
        chk("R7 clock select", 16'(clk_sel), 16'(m_bcs));
        chk("R6 interrupt", 16'(irq), 16'(m_f & m_ie));
        wr_en = wr; rd_en = rd; addr = a; wdata = wd; lock = lk; acq = aq;
        #1;
        last_rd = rdata;
        chk(tag, 16'(rdata), 16'(model_read(a, rd, lk, aq)));
        @(posedge clk);
        model_update(wr, rd, a, wd, lk);
        #1;
        wr_en = 0; rd_en = 0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] wd, input string tag);
        step(1, 0, a, wd, lock, acq, tag);
    endtask

    task automatic rd_lit(input logic [7:0] a, input logic [7:0] exp, input string tag);
        step(0, 1, a, 8'h00, lock, acq, tag);
        chk(tag, 16'(last_rd), 16'(exp));
    endtask

    task automatic pulse_src(input bit use_vco);
        @(negedge clk);
        #2;
        if (use_vco) vco = 1; else osc = 1;
        #2;
        if (use_vco) vco = 0; else osc = 0;
        if (use_vco) m_vd = ~m_vd; else m_od = ~m_od;
        #2;
        chk("R10 base clock", 16'(base_clk), 16'(m_bcs ? m_vd : m_od));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset values
        rd_lit(A_CTRL, 8'h20, "R1 ctrl reset");
        rd_lit(A_BW,   8'h00, "R1 bw reset");
        rd_lit(A_MULH, 8'h00, "R1 mulh reset");
        rd_lit(A_MULL, 8'h40, "R1 mull reset");
        rd_lit(A_RNG,  8'h40, "R1 range reset");
        rd_lit(A_RSV,  8'h01, "R1 reserved reset");
        // R2 map edges
        rd_lit(8'h35, 8'h00, "R2 below window");
        rd_lit(8'h3C, 8'h00, "R2 above window");
        step(0, 0, A_MULL, 8'h00, 0, 0, "R2 idle read data");
        chk("R2 idle read data", 16'(last_rd), 16'h0);

        // R3 manual mode gating
        wr_reg(A_CTRL, 8'hA0, "R3 ie write");
        rd_lit(A_CTRL, 8'h20, "R3 ie held clear");
        step(0, 0, A_CTRL, 8'h00, 1, 0, "R3 lock toggle");
        rd_lit(A_BW, 8'h00, "R3 lock hidden");
        rd_lit(A_CTRL, 8'h20, "R3 flag hidden");
        chk("R3 irq low", 16'(irq), 16'h0);

        // R4 acquisition bit
        wr_reg(A_BW, 8'h20, "R4 acq write");
        rd_lit(A_BW, 8'h20, "R4 acq stored");
        wr_reg(A_BW, 8'h80, "R4 auto on");
        rd_lit(A_BW, 8'hC0, "R4 acq live low");
        acq = 1;
        wr_reg(A_BW, 8'h80, "R4 acq write ignored");
        rd_lit(A_BW, 8'hE0, "R4 acq live high");
        acq = 0;

        // R5 flag set/clear
        step(0, 0, A_MULL, 8'h00, 0, 0, "R5 lock change");
        rd_lit(A_CTRL, 8'h60, "R5 flag set");
        rd_lit(A_CTRL, 8'h20, "R5 flag cleared");
        step(0, 1, A_CTRL, 8'h00, 1, 0, "R5 set and clear");
        rd_lit(A_CTRL, 8'h60, "R5 set wins");

        // R6 interrupt
        wr_reg(A_CTRL, 8'hA0, "R6 ie on");
        step(0, 0, A_MULL, 8'h00, 0, 0, "R6 lock change");
        @(negedge clk);
        chk("R6 irq high", 16'(irq), 16'h1);
        rd_lit(A_CTRL, 8'hE0, "R6 ctrl view");
        @(negedge clk);
        chk("R6 irq cleared", 16'(irq), 16'h0);

        // R9 frozen programming
        wr_reg(A_MULL, 8'h11, "R9 frozen write");
        rd_lit(A_MULL, 8'h40, "R9 mull frozen");
        wr_reg(A_CTRL, 8'h00, "R9 loop off");
        wr_reg(A_MULL, 8'h11, "R9 mull write");
        wr_reg(A_MULH, 8'hFA, "R9 mulh write");
        rd_lit(A_MULH, 8'h0A, "R9 mulh nibble");
        rd_lit(A_MULL, 8'h11, "R9 mull open");
        wr_reg(A_RNG, 8'h00, "R9 range zero");

        // R7 clock select interlock
        wr_reg(A_CTRL, 8'h30, "R7 sel with loop off");
        rd_lit(A_CTRL, 8'h20, "R7 sel refused, loop was off");
        wr_reg(A_CTRL, 8'h30, "R7 sel with zero range");
        rd_lit(A_CTRL, 8'h20, "R7 sel refused, range zero");
        wr_reg(A_CTRL, 8'h00, "R7 loop off");
        wr_reg(A_RNG, 8'h55, "R7 range set");
        wr_reg(A_CTRL, 8'h20, "R7 loop on");
        wr_reg(A_CTRL, 8'h31, "R7 sel accepted");
        rd_lit(A_CTRL, 8'h31, "R7 sel set");

        // R10 clock source
        pulse_src(1); pulse_src(0); pulse_src(1);

        // R8 loop pinned, R11 prescaler
        wr_reg(A_CTRL, 8'h02, "R8 loop off attempt");
        rd_lit(A_CTRL, 8'h22, "R8 loop held");
        chk("R11 prescaler out", 16'(presc), 16'h2);
        pulse_src(0); pulse_src(1); pulse_src(0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit r_wr = ($urandom % 3) == 0;
            bit r_rd = !r_wr && ($urandom % 2);
            logic [7:0] a = 8'h34 + 8'($urandom % 10);
            logic [7:0] wd = 8'($urandom);
            bit lk = (($urandom % 4) == 0) ? ~lock : lock;
            bit aq = 1'($urandom);
            step(r_wr, r_rd, a, wd, lk, aq, "R2 random read");
            if ((i % 16) == 0) pulse_src(1'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule